// File: doc/BRIEF.md
# Size-Aligning Region Decoder for a Shared Memory Bus

This block is the front end that sits between a single bus master and its local memories. Each request carries an address, a size code, a read or write strobe, write data and a debug qualifier. The block first snaps the address down to the natural boundary of the access size. It then uses that snapped address for two things: choosing the target region and forming the offset into the chosen memory.

There are three targets. The first is a main RAM window. The second is a local RAM window, which is either a small work-RAM window or a wider video-RAM window, picked by a build parameter. The third is an I/O window, which is passed out on a separate registered port. Each memory is smaller than its window, so the offset is masked and the contents repeat across the window. Because of this, an address that is unaligned or beyond the memory's size wraps to a valid location instead of raising a fault.

Memory data moves little-endian through byte lanes. Reads return one cycle later. Writes commit on the clock edge through per-byte enables. A tick counter advances once for every access that is not marked as debug.

Top module: `aligned_bus_decoder`

## Requirements
- R1: The address used for decoding, memory offset and I/O forwarding has bits [1:0] cleared for a word access (size code 4), bit 0 cleared for a halfword access (size code 2), and is left unchanged for a byte access (size code 1).
- R2: Snapped addresses 0x0200_0000 to 0x02FF_FFFF reach main RAM at offset = address mod 2^MAIN_AW, so the RAM repeats across the whole window.
- R3: With LOCAL_SEL=0, snapped addresses 0x0380_0000 to 0x0380_FFFF reach local RAM. With LOCAL_SEL=1, snapped addresses 0x0600_0000 to 0x06FF_FFFF reach it. In both cases the offset is address mod 2^LOCAL_AW.
- R4: A request that hits 0x0400_0000 to 0x04FF_FFFF raises io_valid for exactly the next cycle, carrying the snapped address, size, write flag and write data. In that same cycle, a read returns io_rdata unchanged on rsp_rdata.
- R5: Memory data is little-endian: the byte at the lowest offset is bits [7:0]. Byte and halfword reads are zero-extended. A byte or halfword write changes only its own byte lanes.
- R6: Every request produces a one-cycle rsp_valid pulse in the following cycle. A cycle with no request produces none.
- R7: A request that matches no region sets rsp_unmapped and returns rsp_rdata = 0. It changes no memory and raises no io_valid.
- R8: A size code other than 1, 2 or 4 sets rsp_err and returns 0. It touches no memory and no I/O.
- R9: tick is incremented by one for each request with req_dbg=0. It is left unchanged by requests with req_dbg=1, which are otherwise serviced normally.
- R10: After synchronous reset, rsp_valid, io_valid and tick are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dbg | input | 1 | Debug access; does not advance tick |
| req_size | input | 3 | Access size in bytes: 1, 2 or 4 |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data, right-justified |
| rsp_valid | output | 1 | Response pulse, one cycle after the request |
| rsp_rdata | output | 32 | Read data, zero-extended |
| rsp_unmapped | output | 1 | Request hit no region |
| rsp_err | output | 1 | Request had an illegal size code |
| io_valid | output | 1 | I/O access strobe |
| io_write | output | 1 | I/O write flag |
| io_size | output | 3 | I/O access size |
| io_addr | output | 32 | Snapped I/O address |
| io_wdata | output | 32 | I/O write data |
| io_rdata | input | 32 | I/O read data, sampled while io_valid is high |
| tick | output | TICK_W | Count of non-debug accesses |

## Verification
The bench writes known words and then reads them back at every size, using both aligned and deliberately misaligned addresses. A misaligned read only returns the expected value if the low address bits were cleared before the offset was formed, which separates correct snapping from mere truncation of the offset. Sub-word writes are read back as full words, so a write that disturbs the wrong lanes shows up. Accesses to far mirror copies and to addresses just outside a window, followed by read-back, separate correct masking and window bounds from aliasing or unintended writes. I/O accesses at all three sizes show that snapping reaches the forwarded address. Debug-qualified and illegal-size requests show that the tick count and error paths are handled separately from the data path.

// File: rtl/bus_pkg.sv
package bus_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;

  localparam logic [2:0] SZ_BYTE = 3'd1;
  localparam logic [2:0] SZ_HALF = 3'd2;
  localparam logic [2:0] SZ_WORD = 3'd4;

  typedef enum logic [1:0] {
    RGN_NONE  = 2'd0,
    RGN_MAIN  = 2'd1,
    RGN_LOCAL = 2'd2,
    RGN_IO    = 2'd3
  } region_e;

  function automatic logic size_legal(input logic [2:0] sz);
    return (sz == SZ_BYTE) || (sz == SZ_HALF) || (sz == SZ_WORD);
  endfunction

  // lane enables for an access of size sz starting at byte lane lo
  function automatic logic [LANES-1:0] lane_mask(input logic [2:0] sz, input logic [1:0] lo);
    logic [LANES-1:0] m;
    case (sz)
      SZ_WORD: m = 4'b1111;
      SZ_HALF: m = lo[1] ? 4'b1100 : 4'b0011;
      default: m = 4'b0001 << lo;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/bus_region_decode.sv
module bus_region_decode
  import bus_pkg::*;
#(
  parameter int MAIN_AW   = 8,
  parameter int LOCAL_AW  = 8,
  parameter int LOCAL_SEL = 0
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic [2:0]          size,
  output logic [ADDR_W-1:0]   aligned,
  output logic                size_bad,
  output region_e             region,
  output logic [MAIN_AW-1:0]  main_off,
  output logic [LOCAL_AW-1:0] local_off
);
  logic hit_local;

  always_comb begin
    aligned = addr;
    if (size == SZ_WORD) aligned[1:0] = 2'b00;
    else if (size == SZ_HALF) aligned[0] = 1'b0;
  end

  generate
    if (LOCAL_SEL == 0) begin : g_work
      assign hit_local = (aligned[31:16] == 16'h0380);
    end else begin : g_video
      assign hit_local = (aligned[31:24] == 8'h06);
    end
  endgenerate

  always_comb begin
    size_bad = !size_legal(size);
    region   = RGN_NONE;
    if (!size_bad) begin
      if (aligned[31:24] == 8'h02)      region = RGN_MAIN;
      else if (aligned[31:24] == 8'h04) region = RGN_IO;
      else if (hit_local)               region = RGN_LOCAL;
    end
  end

  assign main_off  = aligned[MAIN_AW-1:0];
  assign local_off = aligned[LOCAL_AW-1:0];
endmodule

// File: rtl/bus_lane_ram.sv
module bus_lane_ram
  import bus_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [AW-1:0]     off,
  input  logic [2:0]        size,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rword
);
  localparam int DEPTH = 1 << (AW - 2);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-3:0]     idx;
  logic [LANES-1:0]  be;
  logic [DATA_W-1:0] lanes;

  assign idx = off[AW-1:2];
  assign be  = lane_mask(size, off[1:0]);

  always_comb begin
    case (size)
      SZ_BYTE: lanes = {4{wdata[7:0]}};
      SZ_HALF: lanes = {2{wdata[15:0]}};
      default: lanes = wdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) begin
        for (int b = 0; b < LANES; b++)
          if (be[b]) mem[idx][8*b +: 8] <= lanes[8*b +: 8];
      end else begin
        rword <= mem[idx];
      end
    end
  end
endmodule

// File: rtl/aligned_bus_decoder.sv
module aligned_bus_decoder
  import bus_pkg::*;
#(
  parameter int MAIN_AW   = 8,
  parameter int LOCAL_AW  = 8,
  parameter int LOCAL_SEL = 0,
  parameter int TICK_W    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_dbg,
  input  logic [2:0]        req_size,
  input  logic [31:0]       req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_unmapped,
  output logic              rsp_err,
  output logic              io_valid,
  output logic              io_write,
  output logic [2:0]        io_size,
  output logic [31:0]       io_addr,
  output logic [31:0]       io_wdata,
  input  logic [31:0]       io_rdata,
  output logic [TICK_W-1:0] tick
);
  logic [ADDR_W-1:0]   aligned;
  logic                size_bad;
  region_e             region;
  logic [MAIN_AW-1:0]  main_off;
  logic [LOCAL_AW-1:0] local_off;
  logic [DATA_W-1:0]   main_word, local_word;

  bus_region_decode #(.MAIN_AW(MAIN_AW), .LOCAL_AW(LOCAL_AW), .LOCAL_SEL(LOCAL_SEL)) u_dec (
    .addr(req_addr), .size(req_size), .aligned(aligned), .size_bad(size_bad),
    .region(region), .main_off(main_off), .local_off(local_off)
  );

  bus_lane_ram #(.AW(MAIN_AW)) u_main (
    .clk(clk), .en(req_valid && region == RGN_MAIN), .we(req_write),
    .off(main_off), .size(req_size), .wdata(req_wdata), .rword(main_word)
  );

  bus_lane_ram #(.AW(LOCAL_AW)) u_local (
    .clk(clk), .en(req_valid && region == RGN_LOCAL), .we(req_write),
    .off(local_off), .size(req_size), .wdata(req_wdata), .rword(local_word)
  );

  // response bookkeeping, one stage
  region_e     rgn_q;
  logic        rd_q, err_q;
  logic [1:0]  lo_q;
  logic [2:0]  sz_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      io_valid  <= 1'b0;
      tick      <= '0;
    end else begin
      rsp_valid <= req_valid;
      io_valid  <= req_valid && region == RGN_IO;
      if (req_valid && !req_dbg) tick <= tick + 1'b1;
    end
    rgn_q <= region;
    rd_q  <= !req_write;
    err_q <= size_bad;
    lo_q  <= aligned[1:0];
    sz_q  <= req_size;
    if (req_valid && region == RGN_IO) begin
      io_write <= req_write;
      io_size  <= req_size;
      io_addr  <= aligned;
      io_wdata <= req_wdata;
    end
  end

  logic [DATA_W-1:0] word_sel, shifted;

  always_comb begin
    word_sel = (rgn_q == RGN_MAIN) ? main_word : local_word;
    shifted  = word_sel >> (8 * lo_q);
    rsp_rdata = '0;
    if (rsp_valid && rd_q && !err_q) begin
      case (rgn_q)
        RGN_IO:    rsp_rdata = io_rdata;
        RGN_MAIN, RGN_LOCAL: begin
          case (sz_q)
            SZ_BYTE: rsp_rdata = {24'h0, shifted[7:0]};
            SZ_HALF: rsp_rdata = {16'h0, shifted[15:0]};
            default: rsp_rdata = shifted;
          endcase
        end
        default:   rsp_rdata = '0;
      endcase
    end
    rsp_err      = rsp_valid && err_q;
    rsp_unmapped = rsp_valid && !err_q && rgn_q == RGN_NONE;
  end

  // assertions
  assert_rsp_follows_req_R6: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  assert_no_rsp_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  assert_tick_step_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_dbg) |=> tick == $past(tick) + 1'b1);
  assert_tick_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !req_dbg) |=> $stable(tick));
  assert_io_word_aligned_R1: assert property (@(posedge clk) disable iff (rst)
    (io_valid && io_size == SZ_WORD) |-> io_addr[1:0] == 2'b00);
  assert_io_half_aligned_R1: assert property (@(posedge clk) disable iff (rst)
    (io_valid && io_size == SZ_HALF) |-> io_addr[0] == 1'b0);
  assert_err_no_io_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !size_legal(req_size)) |=> !io_valid);
  assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_unmapped |-> rsp_rdata == '0);
  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    !(rsp_unmapped && rsp_err));
endmodule

// File: tb/test_aligned_bus_decoder.sv
module test_aligned_bus_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 18;

  typedef struct packed {
    logic        wr;
    logic [2:0]  sz;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic        unm;
    logic        err;
  } vec_t;

  // MAIN_AW=8, LOCAL_AW=8, work-RAM map
  localparam vec_t VECS [NV] = '{
    '{1'b1, 3'd4, 32'h0200_0010, 32'h4433_2211, 32'h0, 1'b0, 1'b0}, // R5 word write
    '{1'b0, 3'd4, 32'h0200_0010, 32'h0, 32'h4433_2211, 1'b0, 1'b0}, // R2 R5
    '{1'b0, 3'd1, 32'h0200_0011, 32'h0, 32'h0000_0022, 1'b0, 1'b0}, // R5 byte
    '{1'b0, 3'd2, 32'h0200_0012, 32'h0, 32'h0000_4433, 1'b0, 1'b0}, // R5 half
    '{1'b0, 3'd4, 32'h0200_0013, 32'h0, 32'h4433_2211, 1'b0, 1'b0}, // R1 word snap
    '{1'b0, 3'd2, 32'h0200_0013, 32'h0, 32'h0000_4433, 1'b0, 1'b0}, // R1 half snap
    '{1'b1, 3'd1, 32'h0200_0112, 32'h0000_00AA, 32'h0, 1'b0, 1'b0}, // R2 mirror write
    '{1'b0, 3'd4, 32'h02FF_FF10, 32'h0, 32'h44AA_2211, 1'b0, 1'b0}, // R2 far mirror
    '{1'b1, 3'd4, 32'h0200_0014, 32'h0, 32'h0, 1'b0, 1'b0},
    '{1'b1, 3'd2, 32'h0200_0017, 32'h0000_BEEF, 32'h0, 1'b0, 1'b0}, // R1 R5 lanes
    '{1'b0, 3'd4, 32'h0200_0014, 32'h0, 32'hBEEF_0000, 1'b0, 1'b0}, // R5
    '{1'b1, 3'd4, 32'h0380_0020, 32'hA5A5_5A5A, 32'h0, 1'b0, 1'b0}, // R3
    '{1'b0, 3'd4, 32'h0380_FF20, 32'h0, 32'hA5A5_5A5A, 1'b0, 1'b0}, // R3 mirror
    '{1'b1, 3'd4, 32'h0381_0020, 32'h0000_DEAD, 32'h0, 1'b1, 1'b0}, // R7 outside
    '{1'b0, 3'd4, 32'h0380_0020, 32'h0, 32'hA5A5_5A5A, 1'b0, 1'b0}, // R7 untouched
    '{1'b0, 3'd4, 32'h0000_0000, 32'h0, 32'h0, 1'b1, 1'b0},         // R7
    '{1'b1, 3'd0, 32'h0200_0010, 32'hFFFF_FFFF, 32'h0, 1'b0, 1'b1}, // R8
    '{1'b0, 3'd3, 32'h0200_0010, 32'h0, 32'h0, 1'b0, 1'b1}          // R8
  };

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, req_dbg = 1'b0;
  logic [2:0] req_size = 3'd4;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic rsp_valid, rsp_unmapped, rsp_err;
  logic [31:0] rsp_rdata;
  logic io_valid, io_write;
  logic [2:0] io_size;
  logic [31:0] io_addr, io_wdata;
  logic [31:0] io_rdata = 32'h1357_9BDF;
  logic [31:0] tick;

  int checks = 0, errors = 0, cycles = 0;

  aligned_bus_decoder i_aligned_bus_decoder (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write), .req_dbg(req_dbg),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_unmapped(rsp_unmapped), .rsp_err(rsp_err),
    .io_valid(io_valid), .io_write(io_write), .io_size(io_size), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .tick(tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // drive one request, return at the negedge where its response is visible
  task automatic issue(input logic wr, input logic dbg, input logic [2:0] sz,
                       input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_dbg = dbg;
    req_size = sz; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    logic [31:0] t0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    check("R10 rsp_valid", {31'h0, rsp_valid}, 32'h0);
    check("R10 io_valid", {31'h0, io_valid}, 32'h0);
    check("R10 tick", tick, 32'h0);

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].wr, 1'b0, VECS[i].sz, VECS[i].addr, VECS[i].wdata);
      check("R6 rsp_valid", {31'h0, rsp_valid}, 32'h1);
      check("R5 R1 R2 R3 rdata", rsp_rdata, VECS[i].exp);
      check("R7 unmapped", {31'h0, rsp_unmapped}, {31'h0, VECS[i].unm});
      check("R8 err", {31'h0, rsp_err}, {31'h0, VECS[i].err});
      check("R7 R8 no io", {31'h0, io_valid}, 32'h0);
    end
    check("R9 tick count", tick, NV);

    // R8: illegal-size write left memory intact
    issue(1'b0, 1'b0, 3'd4, 32'h0200_0010, 32'h0);
    check("R8 memory intact", rsp_rdata, 32'h44AA_2211);

    // R6: no response without request
    @(negedge clk);
    check("R6 idle", {31'h0, rsp_valid}, 32'h0);

    // R9: debug access serviced but not counted
    t0 = tick;
    issue(1'b0, 1'b1, 3'd1, 32'h0200_0012, 32'h0);
    check("R9 dbg rdata", rsp_rdata, 32'h0000_00AA);
    check("R9 dbg tick", tick, t0);
    issue(1'b1, 1'b1, 3'd1, 32'h0200_0013, 32'h0000_0077);
    issue(1'b0, 1'b0, 3'd4, 32'h0200_0010, 32'h0);
    check("R9 dbg write done", rsp_rdata, 32'h77AA_2211);
    check("R9 tick after", tick, t0 + 1);

    // R4 and R1 on the I/O port
    issue(1'b1, 1'b0, 3'd4, 32'h0400_0203, 32'hCAFE_F00D);
    check("R4 io_valid", {31'h0, io_valid}, 32'h1);
    check("R1 R4 io_addr word", io_addr, 32'h0400_0200);
    check("R4 io_write", {31'h0, io_write}, 32'h1);
    check("R4 io_size", {29'h0, io_size}, 32'h4);
    check("R4 io_wdata", io_wdata, 32'hCAFE_F00D);
    check("R4 write rdata", rsp_rdata, 32'h0);
    issue(1'b0, 1'b0, 3'd2, 32'h04FF_0011, 32'h0);
    check("R1 R4 io_addr half", io_addr, 32'h04FF_0010);
    check("R4 io read data", rsp_rdata, 32'h1357_9BDF);
    check("R4 io_write read", {31'h0, io_write}, 32'h0);
    issue(1'b0, 1'b0, 3'd1, 32'h0400_0013, 32'h0);
    check("R1 R4 io_addr byte", io_addr, 32'h0400_0013);
    @(negedge clk);
    check("R4 io pulse ends", {31'h0, io_valid}, 32'h0);

    // R3: video window unmapped in the work-RAM build
    issue(1'b0, 1'b0, 3'd4, 32'h0600_0000, 32'h0);
    check("R3 R7 video unmapped", {31'h0, rsp_unmapped}, 32'h1);

    // R10: reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R10 tick after reset", tick, 32'h0);
    check("R10 rsp after reset", {31'h0, rsp_valid}, 32'h0);

    finish_run();
  end
endmodule